// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog

This block is the system tick source of a processor subsystem. A 32-bit up-counter advances by one on every cycle where the tick enable is high. It is compared with four match registers. When the counter steps onto a match value, that channel can latch a sticky status bit, and the status bit drives that channel's interrupt line. Software clears the interrupt by writing a one to the status bit.

Channel 3 has a second role as a one-shot watchdog. If its arm bit is set when channel 3 matches, the block sends a single-cycle reset request and disarms itself. Software reaches all registers through a plain 32-bit register port. A write is qualified by a write strobe. A read is combinational: it returns the register at the presented byte offset.

Byte offsets: match registers 0..3 at 0x00, 0x04, 0x08 and 0x0C; counter at 0x10; status at 0x14; watchdog arm at 0x18; interrupt enable at 0x1C.

Top module: `os_match_timer`

## Requirements
- R1: A synchronous reset clears the counter, all match registers, status, interrupt enable and the watchdog register. After reset every defined offset reads 0, `irq` is 0 and `reset_req` is 0.
- R2: On each clock edge where `tick` is 1, the counter adds one, and 0xFFFFFFFF wraps to 0. Without `tick` it holds its value.
- R3: A write to offset 0x10 loads the counter with the write data, even when `tick` is 1 in the same cycle. The loaded value never produces a match event.
- R4: A match event on channel n happens on a tick edge where the incremented counter equals match register n. If interrupt-enable bit n is 1, status bit n (offset 0x14, bit n) and `irq[n]` become 1 on that edge and stay 1.
- R5: A match event on a channel whose interrupt-enable bit is 0 leaves that status bit and that `irq` line unchanged.
- R6: A write to offset 0x1C stores only bits 11:0 of the write data. Reads of that offset return those 12 bits, zero-extended.
- R7: A write to offset 0x14 clears each status bit where the write data has a 1. Bits written with 0 are kept. `irq[n]` falls with status bit n.
- R8: If a match event sets a status bit in the same cycle that a status write clears it, the bit ends up set.
- R9: A channel-3 match event while bit 0 of the watchdog register (offset 0x18) is 1 drives `reset_req` high for exactly the next cycle and clears the whole watchdog register to 0. This happens whatever interrupt-enable bit 3 holds.
- R10: A channel-3 match event while bit 0 of the watchdog register is 0 does not raise `reset_req` and leaves that register unchanged.
- R11: Reads of any offset other than the eight defined ones return 0. Writes to such offsets change no register.
- R12: A write to a match offset stores the full 32-bit value, and reading the same offset returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 4 | Per-channel interrupt, equal to the status bits |
| reset_req | output | 1 | Single-cycle system reset request from the watchdog |

## Verification
Two things can land on the same clock edge: a match event that sets a status bit, and a software write that clears it. The bench sets a bit, rewinds the counter to one below the match value, and then issues the clearing status write in the same cycle as the tick. It expects the bit to read back as set. A second collision is a counter load in a cycle with `tick` high onto a value equal to a match register. The bench expects the loaded value exactly and no status change. Both the enable pattern and the clear mask are swept over all sixteen values, so every pair of set and clear is covered.

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int DATA_W = 32,
  parameter int N_CH   = 4,
  parameter int IE_W   = 12,
  parameter int ADDR_W = 8,
  parameter int WD_CH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_CH-1:0]   irq,
  output logic              reset_req
);
  localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(4 * N_CH);
  localparam logic [ADDR_W-1:0] OFF_STS = OFF_CNT + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_WD  = OFF_CNT + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_IE  = OFF_CNT + ADDR_W'(12);

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] match_q [N_CH];
  logic [N_CH-1:0]   status, hit;
  logic [IE_W-1:0]   ie;
  logic [DATA_W-1:0] wd;

  wire              cnt_wr   = wr_en && addr == OFF_CNT;
  wire              sts_wr   = wr_en && addr == OFF_STS;
  wire [DATA_W-1:0] count_nx = count + 1'b1;
  wire              wd_fire  = hit[WD_CH] && wd[0];
  wire [N_CH-1:0]   sts_clr  = sts_wr ? (wdata[N_CH-1:0] & status) : '0;

  assign irq = status;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign hit[g] = tick && !cnt_wr && count_nx == match_q[g];
    always_ff @(posedge clk) begin
      if (rst) match_q[g] <= '0;
      else if (wr_en && addr == ADDR_W'(4 * g)) match_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      status    <= '0;
      ie        <= '0;
      wd        <= '0;
      reset_req <= 1'b0;
    end else begin
      if (cnt_wr) count <= wdata;
      else if (tick) count <= count_nx;
      status <= (status & ~sts_clr) | (hit & ie[N_CH-1:0]);
      if (wr_en && addr == OFF_IE) ie <= wdata[IE_W-1:0];
      if (wd_fire) wd <= '0;
      else if (wr_en && addr == OFF_WD) wd <= wdata;
      reset_req <= wd_fire;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++)
      if (addr == ADDR_W'(4 * i)) rdata = match_q[i];
    case (addr)
      OFF_CNT: rdata = count;
      OFF_STS: rdata = DATA_W'(status);
      OFF_WD:  rdata = wd;
      OFF_IE:  rdata = DATA_W'(ie);
      default: ;
    endcase
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> count == $past(count) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(count));
  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status) & ~$past(ie[N_CH-1:0])) == '0));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    ((~status & $past(status)) != '0) |-> $past(sts_wr));
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  assert_disarm_R9: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> wd == '0);
endmodule

// File: tb/os_match_timer_test.sv
module os_match_timer_test;
  logic        clk = 0, rst = 1, tick = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        reset_req;
  int checks = 0, fails = 0;
  logic [31:0] snap [8];

  os_match_timer uut (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
                      .wdata(wdata), .rdata(rdata), .irq(irq), .reset_req(reset_req));

  always #10 clk = ~clk;

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic t = 0);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) rchk("R1 reg", 8'(4 * i), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 reset_req", 32'(reset_req), 0);

    for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'hA5A5_0000 ^ (32'h1111_1111 * n));
    for (int n = 0; n < 4; n++) rchk("R12 match", 8'(4 * n), 32'hA5A5_0000 ^ (32'h1111_1111 * n));

    wr(8'h1C, 32'hFFFF_FFFF);
    rchk("R6 ie mask", 8'h1C, 32'h0000_0FFF);
    wr(8'h1C, 32'h1234_5ABC);
    rchk("R6 ie mask", 8'h1C, 32'h0000_0ABC);
    wr(8'h1C, 0);

    wr(8'h10, 32'hFFFF_FFFD);
    ticks(5);
    rchk("R2 wrap", 8'h10, 32'h2);
    repeat (3) @(negedge clk);
    rchk("R2 hold", 8'h10, 32'h2);
    ticks(7);
    rchk("R2 step", 8'h10, 32'h9);

    for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'h1000 + 32'(n) + 1);
    wr(8'h1C, 32'hF);
    wr(8'h14, 32'hF);
    wr(8'h10, 32'h1001, 1'b1);
    rchk("R3 load over tick", 8'h10, 32'h1001);
    rchk("R3 load no match", 8'h14, 32'h0);

    for (int p = 0; p < 16; p++) begin
      for (int w = 0; w < 16; w++) begin
        wr(8'h1C, 32'(p));
        wr(8'h14, 32'hF);
        wr(8'h10, 32'h1000);
        ticks(4);
        rchk("R4/R5 status", 8'h14, 32'(p));
        chk("R4/R5 irq", 32'(irq), 32'(p));
        wr(8'h14, 32'(w) | 32'hFFFF_FF00);
        rchk("R7 w1c", 8'h14, 32'(p & ~w & 4'hF));
        chk("R7 irq", 32'(irq), 32'(p & ~w & 4'hF));
      end
    end

    wr(8'h1C, 32'hF);
    wr(8'h14, 32'hF);
    wr(8'h10, 32'h1000);
    ticks(1);
    rchk("R8 setup", 8'h14, 32'h1);
    wr(8'h10, 32'h1000);
    wr(8'h14, 32'h1, 1'b1);
    rchk("R8 set wins", 8'h14, 32'h1);
    chk("R8 irq", 32'(irq), 32'h1);

    wr(8'h1C, 0);
    wr(8'h14, 32'hF);
    wr(8'h0C, 32'd200);
    wr(8'h10, 32'd199);
    wr(8'h18, 32'h8000_0001);
    rchk("R9 armed", 8'h18, 32'h8000_0001);
    ticks(1);
    chk("R9 pulse", 32'(reset_req), 1);
    rchk("R9 disarm", 8'h18, 0);
    rchk("R9 no status", 8'h14, 0);
    @(negedge clk);
    chk("R9 one cycle", 32'(reset_req), 0);

    wr(8'h10, 32'd199);
    wr(8'h18, 32'hFFFF_FFFE);
    ticks(1);
    chk("R10 no pulse", 32'(reset_req), 0);
    @(negedge clk);
    chk("R10 no pulse later", 32'(reset_req), 0);
    rchk("R10 kept", 8'h18, 32'hFFFF_FFFE);

    wr(8'h1C, 32'h5);
    for (int i = 0; i < 8; i++) begin
      rd(8'(4 * i), v);
      snap[i] = v;
    end
    for (int a = 8'h20; a < 256; a++) begin
      wr(8'(a), 32'hFFFF_FFFF);
      if (a % 16 == 1) rchk("R11 read zero", 8'(a), 0);
    end
    for (int a = 1; a < 32; a += 4) rchk("R11 unaligned zero", 8'(a), 0);
    for (int i = 0; i < 8; i++) rchk("R11 unchanged", 8'(4 * i), snap[i]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule